// File: doc/BRIEF.md
# Test-per-Clock Random Stimulus Driver

This block drives stimulus into a circuit that is being authenticated by its supply current. The aim is switching activity, not a logic check. A new pattern goes out on every clock cycle while a run is active. Each pattern has two parts: one pseudo-random bit for the serial scan input, and a fresh pseudo-random word for the primary inputs. Both come from a single 32-bit Galois LFSR, which is stepped 17 times per cycle, so every output bit of a pattern is a distinct bit of the sequence.

A run starts from idle. The start pulse latches a pattern budget. The run ends in one of two ways: the budget is used up, or an external flag reports that the integrated current difference has crossed its threshold. The block then drops scan enable, pulses done for one cycle and freezes the pattern count for readout. The 24-bit budget allows runs of more than a million patterns. Responses of the circuit are neither captured nor compared.

Top module: `rand_stim_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the block idle with `scan_en`, `done`, `scan_in`, `pi_word` and `pat_count` all zero, and the generator state set to the default seed 32'h1F35A9C7.
- R2: In idle, `seed_load` without `start` loads `seed_in` into the generator state; a zero seed loads the default seed 32'h1F35A9C7 instead. If `start` and `seed_load` arrive together, `start` wins.
- R3: One generator step takes the emitted bit from state bit 0, shifts the state right by one, and XORs in mask 32'h80200003 when the emitted bit was 1.
- R4: Each applied pattern consumes 17 consecutive emitted bits. The first 16 bits go to `pi_word`, bit 0 first. The 17th bit goes to `scan_in`.
- R5: `start` in idle with a nonzero `budget` latches the budget and applies the first pattern on that same edge. After that edge, `scan_en` is 1 and `pat_count` is 1.
- R6: While running, each edge without a stop condition applies a new pattern and increments `pat_count` by exactly one. The edge at which `pat_count` equals the latched budget applies no pattern and ends the run, so a run applies exactly `budget` patterns.
- R7: A run also ends at any edge where `detect` is high while running; no pattern is applied at that edge.
- R8: At the edge that ends a run, `done` goes high for exactly one cycle and `scan_en` goes low. `pat_count`, `pi_word` and `scan_in` hold their values until the next start.
- R9: `start` with `budget` zero applies no pattern: `pat_count` becomes 0, `done` pulses on that edge, and `scan_en` stays low.
- R10: `start` and `seed_load` during a run have no effect: the count, the run length and the pattern sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run from idle |
| seed_load | input | 1 | Load generator seed while idle |
| seed_in | input | 32 | Seed value |
| budget | input | 24 | Maximum number of patterns for the run |
| detect | input | 1 | Threshold-reached flag; stops the run |
| scan_en | output | 1 | High while patterns are being applied |
| scan_in | output | 1 | Serial bit shifted into the scan chain |
| pi_word | output | 16 | Pseudo-random primary-input word |
| done | output | 1 | One-cycle pulse when a run ends |
| pat_count | output | 24 | Patterns applied in the current or last run |

## Verification
The checker watches several run-control properties on every cycle: the one-cycle width of done, an unchanging count while idle, a step of exactly one per cycle while running, an immediate stop after detect, and scan enable being low whenever done is high. What only the bench's scenarios can show is the exact bit sequence: that pi_word and scan_in follow the stated polynomial and bit order, that zero and explicit seeds take effect, that a run lasts exactly the budget, and that start or seed pulses in the middle of a run leave the sequence untouched.

// File: rtl/rand_stim_gen.sv
module rand_stim_gen #(
  parameter int                LFSR_W       = 32,
  parameter logic [LFSR_W-1:0] POLY_MASK    = 32'h8020_0003,
  parameter logic [LFSR_W-1:0] DEFAULT_SEED = 32'h1F35_A9C7,
  parameter int                PI_W         = 16,
  parameter int                CNT_W        = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_in,
  input  logic [CNT_W-1:0]  budget,
  input  logic              detect,
  output logic              scan_en,
  output logic              scan_in,
  output logic [PI_W-1:0]   pi_word,
  output logic              done,
  output logic [CNT_W-1:0]  pat_count
);

  localparam int BITS_PER_PAT = PI_W + 1;

  logic [LFSR_W-1:0]       lfsr_q, lfsr_adv, walk;
  logic [BITS_PER_PAT-1:0] pat_bits;
  logic [CNT_W-1:0]        budget_q;
  logic                    run_q, done_q, scan_q;
  logic [PI_W-1:0]         pi_q;
  logic [CNT_W-1:0]        cnt_q;
  logic                    stop_now;

  always_comb begin
    walk = lfsr_q;
    for (int i = 0; i < BITS_PER_PAT; i++) begin
      pat_bits[i] = walk[0];
      walk = (walk >> 1) ^ (walk[0] ? POLY_MASK : '0);
    end
    lfsr_adv = walk;
  end

  assign stop_now = detect || (cnt_q == budget_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      scan_q   <= 1'b0;
      pi_q     <= '0;
      cnt_q    <= '0;
      budget_q <= '0;
      lfsr_q   <= DEFAULT_SEED;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start) begin
          budget_q <= budget;
          if (budget == '0) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            run_q  <= 1'b1;
            cnt_q  <= CNT_W'(1);
            pi_q   <= pat_bits[PI_W-1:0];
            scan_q <= pat_bits[PI_W];
            lfsr_q <= lfsr_adv;
          end
        end else if (seed_load) begin
          lfsr_q <= (seed_in == '0) ? DEFAULT_SEED : seed_in;
        end
      end else if (stop_now) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
        pi_q   <= pat_bits[PI_W-1:0];
        scan_q <= pat_bits[PI_W];
        lfsr_q <= lfsr_adv;
      end
    end
  end

  assign scan_en   = run_q;
  assign scan_in   = scan_q;
  assign pi_word   = pi_q;
  assign done      = done_q;
  assign pat_count = cnt_q;

endmodule

// File: rtl/rand_stim_gen_chk.sv
module rand_stim_gen_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             detect,
  input logic             scan_en,
  input logic             done,
  input logic [CNT_W-1:0] pat_count
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

  AST_DONE_NOT_RUNNING: assert property (@(posedge clk) disable iff (rst)
    done |-> !scan_en); // R8

  AST_IDLE_COUNT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !start) |=> $stable(pat_count)); // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (scan_en && $past(scan_en)) |-> pat_count == $past(pat_count) + CNT_W'(1)); // R6

  AST_DETECT_HALTS: assert property (@(posedge clk) disable iff (rst)
    (scan_en && detect) |=> (!scan_en && done && $stable(pat_count))); // R7

  AST_RUN_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> pat_count != '0); // R5

endmodule

bind rand_stim_gen rand_stim_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .detect(detect),
  .scan_en(scan_en), .done(done), .pat_count(pat_count)
);

// File: tb/rand_stim_gen_test.sv
`timescale 1ns/1ps
module rand_stim_gen_test;

  localparam logic [31:0] MASK = 32'h8020_0003;
  localparam logic [31:0] DEF  = 32'h1F35_A9C7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, seed_load = 1'b0, detect = 1'b0;
  logic [31:0] seed_in = '0;
  logic [23:0] budget = '0;
  logic        scan_en, scan_in, done;
  logic [15:0] pi_word;
  logic [23:0] pat_count;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] mdl;

  always #2 clk = ~clk;

  rand_stim_gen uut (
    .clk(clk), .rst(rst), .start(start), .seed_load(seed_load),
    .seed_in(seed_in), .budget(budget), .detect(detect),
    .scan_en(scan_en), .scan_in(scan_in), .pi_word(pi_word),
    .done(done), .pat_count(pat_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3/R4 model: 17 emitted bits per pattern
  task automatic next_pat(output logic [15:0] p, output logic s);
    logic b;
    for (int i = 0; i < 17; i++) begin
      b = mdl[0];
      mdl = (mdl >> 1) ^ (b ? MASK : 32'h0);
      if (i < 16) p[i] = b; else s = b;
    end
  endtask

  task automatic load_seed(input logic [31:0] s);
    @(negedge clk); seed_load = 1'b1; seed_in = s;
    @(posedge clk); @(negedge clk); seed_load = 1'b0;
    mdl = (s == 32'h0) ? DEF : s;
  endtask

  task automatic run(input int b, input int det_at, input bit poke);
    logic [15:0] ep; logic es; int k;
    @(negedge clk); start = 1'b1; budget = 24'(b);
    @(posedge clk); @(negedge clk); start = 1'b0;
    if (b == 0) begin
      chk("R9 done", done, 1); chk("R9 scan_en", scan_en, 0); chk("R9 count", pat_count, 0);
      @(posedge clk); @(negedge clk); chk("R8 done pulse", done, 0);
      return;
    end
    k = 1;
    forever begin
      next_pat(ep, es);
      start = 1'b0; seed_load = 1'b0;
      chk("R4 pi_word", pi_word, ep);
      chk("R4 scan_in", scan_in, es);
      chk(k == 1 ? "R5 count" : "R6 count", pat_count, k);
      chk("R5 scan_en", scan_en, 1);
      if (k == 2 && poke) begin
        start = 1'b1; seed_load = 1'b1; seed_in = $urandom; // R10
      end
      if (k == det_at) detect = 1'b1;
      if (k == b || k == det_at) break;
      @(posedge clk); @(negedge clk);
      k++;
    end
    @(posedge clk); @(negedge clk);
    detect = 1'b0; start = 1'b0; seed_load = 1'b0;
    chk(k == det_at ? "R7 done" : "R6 done", done, 1);
    chk("R8 scan_en", scan_en, 0);
    chk(k == det_at ? "R7 count" : "R6 count", pat_count, k);
    chk("R8 pi hold", pi_word, ep);
    chk("R8 scan hold", scan_in, es);
    @(posedge clk); @(negedge clk);
    chk("R8 done pulse", done, 0);
    chk("R8 count frozen", pat_count, k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1 scan_en", scan_en, 0); chk("R1 done", done, 0);
    chk("R1 count", pat_count, 0); chk("R1 pi", pi_word, 0); chk("R1 scan", scan_in, 0);
    mdl = DEF;
    run(5, 0, 0);                 // R1 default seed sequence, R6 budget end
    load_seed(32'hDEAD_BEEF);     // R2
    run(9, 0, 1);                 // R10 poke mid-run
    load_seed(32'h0);             // R2 zero seed
    run(4, 0, 0);
    load_seed(32'h1234_5678);
    run(100, 7, 0);               // R7 early stop
    run(0, 0, 0);                 // R9
    run(1, 0, 0);                 // R6 minimum budget
    run(6, 1, 0);                 // R7 stop after first pattern
    @(negedge clk); start = 1'b1; seed_load = 1'b1; seed_in = 32'hFFFF_0000; budget = 24'd3;
    @(posedge clk); @(negedge clk); start = 1'b0; seed_load = 1'b0;
    chk("R2 start wins count", pat_count, 1);
    begin logic [15:0] p; logic s; next_pat(p, s); chk("R2 start wins pi", pi_word, p); end
    repeat (3) @(posedge clk); @(negedge clk);
    begin logic [15:0] p; logic s; next_pat(p, s); next_pat(p, s); end
    chk("R6 done after budget", pat_count, 3);
    for (int r = 0; r < 25; r++) begin
      int b, d;
      if ($urandom_range(0, 2) == 0) load_seed($urandom);
      b = $urandom_range(1, 60);
      d = ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, b);
      run(b, d, bit'($urandom_range(0, 1)));
    end
    run(3000, 0, 0);
    @(negedge clk); rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    chk("R1 reset count", pat_count, 0); chk("R1 reset pi", pi_word, 0);
    mdl = DEF;
    run(2, 0, 0);                 // R1 default seed after reset
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule